// File: doc/BRIEF.md
# Halt and Peripheral Clock-Gating Controller

This controller parks the processor in a halt state on request and releases it when a qualifying wake event arrives. The system clock keeps running while the core is parked. The CPU only sees its run enable drop, so the program counter stops advancing. A 3-bit cause code records which source ended the halt.

The same block holds a bank of power-down bits, written and read over a small register bus. Each bit removes the clock enable of one peripheral. It also blocks register accesses to that peripheral: the read data is forced to zero, the access is refused and an error flag is raised. One peripheral, the network receive unit, keeps its clock while the core is halted, so that a received packet can still raise the interrupt that wakes the core.

The wake sequencing is a two-state machine. RUN is the reset state, in which `cpu_run` is high. The transition HALT_ENTER goes from RUN to HALT when `halt_req` is sampled. In HALT, `cpu_run` is low. The transition WAKE_EXIT goes from HALT back to RUN when a qualifying wake event is sampled.

Top module: `halt_clkgate_ctrl`

## Requirements
- R1: After reset the controller behaves as follows:
  - `cpu_run` is 1.
  - Every bit of `clk_en` is 1.
  - Both power-down registers read back 0x00.
  - `wake_cause` is 0.
- R2: When `halt_req` is sampled high while running, `cpu_run` is 0 from the next cycle and `wake_cause` is cleared to 0 in that same cycle.
- R3: While halted, a qualifying wake event sets `cpu_run` back to 1 on the next cycle. Without one the core stays halted and the clock enables keep their values.
- R4: A maskable interrupt `irq` qualifies only when `irq_gie` is 1. A watchdog timeout qualifies only when `wdt_wake_en` is 1. `ext_rst_req`, `dbg_rst_cmd` and `nmi` always qualify.
- R5: On WAKE_EXIT, `wake_cause` captures the highest-priority active source, in this priority order:

  | Priority | Source | Code |
  |---|---|---|
  | 1 (highest) | external reset | 1 |
  | 2 | debug reset | 2 |
  | 3 | watchdog | 3 |
  | 4 | NMI | 4 |
  | 5 (lowest) | maskable interrupt | 5 |

  The code holds until the next halt entry.
- R6: Bit i of power-down register address 0 controls peripheral i. Bit i of address 1 controls peripheral 8+i. Writing 1 drops that peripheral's `clk_en` bit and writing 0 restores it. The change appears only in the cycle after the write.
- R7: Bits with no peripheral (default: peripheral 15 only) ignore writes, read back 0, and keep their `clk_en` bit at 1.
- R8: An access to a powered-down peripheral gives all of the following in the same cycle:
  - `acc_grant` is all zero.
  - `acc_rdata` is 0x00.
  - `acc_err` is 1.
- R9: An access to a powered peripheral gives all of the following:
  - Exactly the `acc_grant` bit selected by `acc_id` is 1.
  - `acc_rdata` equals `periph_rdata`.
  - `acc_err` is 0.
- R10: The exempt receive peripheral (default index 5) keeps `clk_en` at 1 while halted, even when its power-down bit is set. While running it follows its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Halt request from the CPU |
| ext_rst_req | input | 1 | Synchronised external reset pin event |
| dbg_rst_cmd | input | 1 | Debug reset command |
| wdt_timeout | input | 1 | Watchdog timeout |
| wdt_wake_en | input | 1 | Watchdog configured to raise NMI or reset |
| nmi | input | 1 | Nonmaskable interrupt |
| irq | input | 1 | Maskable interrupt (any source, including network receive) |
| irq_gie | input | 1 | Global maskable-interrupt enable |
| bus_sel | input | 1 | Register bus select for the power-down registers |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 1 | Power-down register address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Power-down register read data |
| acc_valid | input | 1 | Peripheral register access request |
| acc_id | input | 4 | Target peripheral index |
| periph_rdata | input | 8 | Read data from the addressed peripheral |
| acc_grant | output | 16 | One-hot access grant to peripherals |
| acc_rdata | output | 8 | Read data returned to the CPU |
| acc_err | output | 1 | Blocked-access flag |
| clk_en | output | 16 | Per-peripheral clock enables |
| cpu_run | output | 1 | CPU run enable |
| wake_cause | output | 3 | Cause code of the last wake |

## Verification
The bench targets several ways the design could go wrong, and each one shows up as a wrong output:
- Simultaneous wake sources: a wrong priority encoder returns a lower-ranked code.
- A maskable interrupt with the global enable low, or a watchdog timeout without its wake enable: a design that ignores qualification leaves halt too early.
- A write to a power-down register: a clock enable that follows the write data combinationally changes one cycle early.
- The exempt receive peripheral: if the halt exemption is left out, its clock enable drops during halt.
- A write to the absent bit: if the mask is missing, that bit reads back as 1.
- An access to a powered-down peripheral: broken blocking lets the peripheral's data through or asserts a grant.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } hcg_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_XRST = 3'd1,
        CAUSE_DBG  = 3'd2,
        CAUSE_WDT  = 3'd3,
        CAUSE_NMI  = 3'd4,
        CAUSE_IRQ  = 3'd5
    } hcg_cause_e;
endpackage

// File: rtl/hcg_wake_fsm.sv
module hcg_wake_fsm
    import hcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       ext_rst_req,
    input  logic       dbg_rst_cmd,
    input  logic       wdt_timeout,
    input  logic       wdt_wake_en,
    input  logic       nmi,
    input  logic       irq,
    input  logic       irq_gie,
    output logic       cpu_run,
    output logic       halted,
    output logic [2:0] wake_cause
);
    hcg_state_e state_q, state_d;
    hcg_cause_e cause_q, cause_sel;
    logic       wdt_ok, irq_ok, wake_ok;

    assign wdt_ok  = wdt_timeout & wdt_wake_en;
    assign irq_ok  = irq & irq_gie;
    assign wake_ok = ext_rst_req | dbg_rst_cmd | wdt_ok | nmi | irq_ok;

    // fixed priority: external reset, debug reset, watchdog, NMI, interrupt
    always_comb begin
        if (ext_rst_req)      cause_sel = CAUSE_XRST;
        else if (dbg_rst_cmd) cause_sel = CAUSE_DBG;
        else if (wdt_ok)      cause_sel = CAUSE_WDT;
        else if (nmi)         cause_sel = CAUSE_NMI;
        else if (irq_ok)      cause_sel = CAUSE_IRQ;
        else                  cause_sel = CAUSE_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (halt_req) state_d = ST_HALT;   // HALT_ENTER
            ST_HALT: if (wake_ok)  state_d = ST_RUN;    // WAKE_EXIT
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_RUN:  if (halt_req) cause_q <= CAUSE_NONE;
                ST_HALT: if (wake_ok)  cause_q <= cause_sel;
                default: cause_q <= CAUSE_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  begin cpu_run = 1'b1; halted = 1'b0; end
            ST_HALT: begin cpu_run = 1'b0; halted = 1'b1; end
            default: begin cpu_run = 1'b1; halted = 1'b0; end
        endcase
        wake_cause = cause_q;
    end
endmodule

// File: rtl/hcg_pd_regs.sv
module hcg_pd_regs #(
    parameter int                    NUM_PERIPH   = 16,
    parameter logic [NUM_PERIPH-1:0] PRESENT_MASK = 16'h7FFF,
    parameter int                    EXEMPT_IDX   = 5,
    localparam int                   NUM_REGS     = (NUM_PERIPH + 7) / 8,
    localparam int                   PAD_W        = NUM_REGS * 8,
    localparam int                   ADDR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halted,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic [NUM_PERIPH-1:0] pd_bits,
    output logic [NUM_PERIPH-1:0] clk_en
);
    localparam logic [PAD_W-1:0] MASK_FULL = PAD_W'(PRESENT_MASK);

    logic [PAD_W-1:0]      pd_q;
    logic [NUM_PERIPH-1:0] exempt_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= '0;
        end else if (bus_sel && bus_wr) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (bus_addr == ADDR_W'(r))
                    pd_q[r*8 +: 8] <= bus_wdata & MASK_FULL[r*8 +: 8];
            end
        end
    end

    assign bus_rdata = pd_q[{bus_addr, 3'b000} +: 8];
    assign pd_bits   = pd_q[NUM_PERIPH-1:0];

    generate
        if (EXEMPT_IDX >= 0 && EXEMPT_IDX < NUM_PERIPH) begin : g_exempt
            always_comb begin
                exempt_mask = '0;
                exempt_mask[EXEMPT_IDX] = halted;
            end
        end else begin : g_no_exempt
            assign exempt_mask = '0;
        end
    endgenerate

    assign clk_en = ~pd_bits | exempt_mask;
endmodule

// File: rtl/hcg_access_gate.sv
module hcg_access_gate #(
    parameter int  NUM_PERIPH = 16,
    localparam int ID_W       = $clog2(NUM_PERIPH)
) (
    input  logic                  acc_valid,
    input  logic [ID_W-1:0]       acc_id,
    input  logic [NUM_PERIPH-1:0] pd_bits,
    input  logic [7:0]            periph_rdata,
    output logic [NUM_PERIPH-1:0] acc_grant,
    output logic [7:0]            acc_rdata,
    output logic                  acc_err
);
    logic target_off;

    assign target_off = pd_bits[acc_id];

    always_comb begin
        acc_grant = '0;
        if (acc_valid && !target_off) acc_grant[acc_id] = 1'b1;
    end

    assign acc_err   = acc_valid & target_off;
    assign acc_rdata = (acc_valid && !target_off) ? periph_rdata : 8'h00;
endmodule

// File: rtl/halt_clkgate_ctrl.sv
module halt_clkgate_ctrl #(
    parameter int                    NUM_PERIPH   = 16,
    parameter logic [NUM_PERIPH-1:0] PRESENT_MASK = 16'h7FFF,
    parameter int                    EXEMPT_IDX   = 5,
    localparam int                   NUM_REGS     = (NUM_PERIPH + 7) / 8,
    localparam int                   ADDR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int                   ID_W         = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt_req,
    input  logic                  ext_rst_req,
    input  logic                  dbg_rst_cmd,
    input  logic                  wdt_timeout,
    input  logic                  wdt_wake_en,
    input  logic                  nmi,
    input  logic                  irq,
    input  logic                  irq_gie,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  acc_valid,
    input  logic [ID_W-1:0]       acc_id,
    input  logic [7:0]            periph_rdata,
    output logic [NUM_PERIPH-1:0] acc_grant,
    output logic [7:0]            acc_rdata,
    output logic                  acc_err,
    output logic [NUM_PERIPH-1:0] clk_en,
    output logic                  cpu_run,
    output logic [2:0]            wake_cause
);
    logic                  halted;
    logic [NUM_PERIPH-1:0] pd_bits;

    hcg_wake_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .ext_rst_req (ext_rst_req),
        .dbg_rst_cmd (dbg_rst_cmd),
        .wdt_timeout (wdt_timeout),
        .wdt_wake_en (wdt_wake_en),
        .nmi         (nmi),
        .irq         (irq),
        .irq_gie     (irq_gie),
        .cpu_run     (cpu_run),
        .halted      (halted),
        .wake_cause  (wake_cause)
    );

    hcg_pd_regs #(
        .NUM_PERIPH   (NUM_PERIPH),
        .PRESENT_MASK (PRESENT_MASK),
        .EXEMPT_IDX   (EXEMPT_IDX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted    (halted),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pd_bits   (pd_bits),
        .clk_en    (clk_en)
    );

    hcg_access_gate #(
        .NUM_PERIPH (NUM_PERIPH)
    ) u_gate (
        .acc_valid    (acc_valid),
        .acc_id       (acc_id),
        .pd_bits      (pd_bits),
        .periph_rdata (periph_rdata),
        .acc_grant    (acc_grant),
        .acc_rdata    (acc_rdata),
        .acc_err      (acc_err)
    );
endmodule

// File: rtl/hcg_chk.sv
module hcg_chk #(
    parameter int NUM_PERIPH = 16,
    parameter int EXEMPT_IDX = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  halt_req,
    input logic                  ext_rst_req,
    input logic                  dbg_rst_cmd,
    input logic                  wdt_timeout,
    input logic                  wdt_wake_en,
    input logic                  nmi,
    input logic                  irq,
    input logic                  irq_gie,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [NUM_PERIPH-1:0] acc_grant,
    input logic [7:0]            acc_rdata,
    input logic                  acc_err,
    input logic [NUM_PERIPH-1:0] clk_en,
    input logic                  cpu_run,
    input logic [2:0]            wake_cause
);
    logic wake_ok;
    logic above_nmi;
    assign wake_ok   = ext_rst_req | dbg_rst_cmd | (wdt_timeout & wdt_wake_en) | nmi | (irq & irq_gie);
    assign above_nmi = ext_rst_req | dbg_rst_cmd | (wdt_timeout & wdt_wake_en);

    // R2
    halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && halt_req) |=> !cpu_run);
    // R2
    cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && halt_req) |=> (wake_cause == 3'd0));
    // R3
    wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && wake_ok) |=> cpu_run);
    // R4
    stay_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && !wake_ok) |=> !cpu_run);
    // R5
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && !halt_req) |=> $stable(wake_cause));
    // R5
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && nmi && !above_nmi) |=> (wake_cause == 3'd4));
    // R6
    clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && !halt_req && !(bus_sel && bus_wr)) |=> $stable(clk_en));
    // R8
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_grant == '0 && acc_rdata == 8'h00));
    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_grant));
    // R10
    exempt_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |-> clk_en[EXEMPT_IDX]);
endmodule

bind halt_clkgate_ctrl hcg_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .EXEMPT_IDX (EXEMPT_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .ext_rst_req (ext_rst_req),
    .dbg_rst_cmd (dbg_rst_cmd),
    .wdt_timeout (wdt_timeout),
    .wdt_wake_en (wdt_wake_en),
    .nmi         (nmi),
    .irq         (irq),
    .irq_gie     (irq_gie),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .acc_grant   (acc_grant),
    .acc_rdata   (acc_rdata),
    .acc_err     (acc_err),
    .clk_en      (clk_en),
    .cpu_run     (cpu_run),
    .wake_cause  (wake_cause)
);

// File: tb/halt_clkgate_ctrl_tb.sv
`timescale 1ns/1ps
module halt_clkgate_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_req = 0, ext_rst_req = 0, dbg_rst_cmd = 0, wdt_timeout = 0;
    logic        wdt_wake_en = 0, nmi = 0, irq = 0, irq_gie = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [0:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        acc_valid = 0;
    logic [3:0]  acc_id = '0;
    logic [7:0]  periph_rdata = 8'hA5, acc_rdata;
    logic [15:0] acc_grant, clk_en;
    logic        acc_err, cpu_run;
    logic [2:0]  wake_cause;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    halt_clkgate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ext_rst_req(ext_rst_req),
        .dbg_rst_cmd(dbg_rst_cmd), .wdt_timeout(wdt_timeout), .wdt_wake_en(wdt_wake_en),
        .nmi(nmi), .irq(irq), .irq_gie(irq_gie), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .acc_valid(acc_valid), .acc_id(acc_id), .periph_rdata(periph_rdata),
        .acc_grant(acc_grant), .acc_rdata(acc_rdata), .acc_err(acc_err),
        .clk_en(clk_en), .cpu_run(cpu_run), .wake_cause(wake_cause)
    );

    // {ext_rst, dbg, wdt, nmi, irq} [9:5], wdt_wake_en [4], irq_gie [3], expected cause [2:0]
    // expected cause 0 means the core must stay halted
    localparam logic [9:0] VEC [12] = '{
        {5'b00001, 1'b0, 1'b1, 3'd5},
        {5'b00001, 1'b1, 1'b0, 3'd0},
        {5'b00010, 1'b0, 1'b0, 3'd4},
        {5'b00100, 1'b1, 1'b0, 3'd3},
        {5'b00100, 1'b0, 1'b1, 3'd0},
        {5'b01000, 1'b0, 1'b0, 3'd2},
        {5'b10000, 1'b0, 1'b0, 3'd1},
        {5'b11111, 1'b1, 1'b1, 3'd1},
        {5'b01111, 1'b1, 1'b1, 3'd2},
        {5'b00111, 1'b1, 1'b1, 3'd3},
        {5'b00111, 1'b0, 1'b1, 3'd4},
        {5'b00011, 1'b1, 1'b1, 3'd4}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_src();
        ext_rst_req = 0; dbg_rst_cmd = 0; wdt_timeout = 0; nmi = 0; irq = 0;
        wdt_wake_en = 0; irq_gie = 0;
    endtask

    task automatic enter_halt();
        halt_req = 1;
        tick();
        halt_req = 0;
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cpu_run", 32'(cpu_run), 32'd1);
        check("R1", "clk_en", 32'(clk_en), 32'hFFFF);
        check("R1", "cause", 32'(wake_cause), 32'd0);
        bus_addr = 1'b0; #0.5;
        check("R1", "reg0", 32'(bus_rdata), 32'h00);
        bus_addr = 1'b1; #0.5;
        check("R1", "reg1", 32'(bus_rdata), 32'h00);

        // wake vector table: R2 R3 R4 R5
        for (int i = 0; i < 12; i++) begin
            enter_halt();
            check("R2", "cpu_run after halt", 32'(cpu_run), 32'd0);
            check("R2", "cause cleared", 32'(wake_cause), 32'd0);
            {ext_rst_req, dbg_rst_cmd, wdt_timeout, nmi, irq} = VEC[i][9:5];
            wdt_wake_en = VEC[i][4];
            irq_gie     = VEC[i][3];
            tick();
            clear_src();
            if (VEC[i][2:0] == 3'd0) begin
                check("R4", "unqualified stays halted", 32'(cpu_run), 32'd0);
                check("R3", "clk_en held in halt", 32'(clk_en), 32'hFFFF);
                nmi = 1;
                tick();
                nmi = 0;
                check("R3", "nmi wakes", 32'(cpu_run), 32'd1);
            end else begin
                check("R3", "wake restores run", 32'(cpu_run), 32'd1);
                check("R5", "cause code", 32'(wake_cause), 32'(VEC[i][2:0]));
                tick();
                check("R5", "cause held", 32'(wake_cause), 32'(VEC[i][2:0]));
            end
        end

        // R6 timing: write reg0 bit 2 and bit 5
        bus_sel = 1; bus_wr = 1; bus_addr = 1'b0; bus_wdata = 8'h24;
        #0.5;
        check("R6", "clk_en before edge", 32'(clk_en), 32'hFFFF);
        tick();
        bus_sel = 0; bus_wr = 0;
        check("R6", "clk_en after write", 32'(clk_en), 32'hFFDB);
        bus_addr = 1'b0; #0.5;
        check("R6", "reg0 readback", 32'(bus_rdata), 32'h24);

        // R7 absent bit 15
        reg_write(1'b1, 8'hFF);
        bus_addr = 1'b1; #0.5;
        check("R7", "reg1 readback", 32'(bus_rdata), 32'h7F);
        check("R7", "absent clk_en", 32'(clk_en[15]), 32'd1);
        check("R6", "reg1 clk_en", 32'(clk_en), 32'h80DB);

        // R8 blocked read of peripheral 2
        acc_valid = 1; acc_id = 4'd2; #0.5;
        check("R8", "grant", 32'(acc_grant), 32'h0);
        check("R8", "rdata", 32'(acc_rdata), 32'h00);
        check("R8", "err", 32'(acc_err), 32'd1);
        // R9 granted access to peripheral 3
        acc_id = 4'd3; #0.5;
        check("R9", "grant", 32'(acc_grant), 32'h0008);
        check("R9", "rdata", 32'(acc_rdata), 32'hA5);
        check("R9", "err", 32'(acc_err), 32'd0);
        acc_valid = 0;

        // R10 exempt peripheral 5 while halted
        check("R10", "exempt off while running", 32'(clk_en[5]), 32'd0);
        enter_halt();
        check("R10", "exempt on while halted", 32'(clk_en[5]), 32'd1);
        check("R10", "others still off", 32'(clk_en[2]), 32'd0);
        irq = 1; irq_gie = 1;
        tick();
        clear_src();
        check("R10", "irq wakes core", 32'(cpu_run), 32'd1);
        check("R10", "exempt follows bit again", 32'(clk_en[5]), 32'd0);

        // R6 clearing restores
        reg_write(1'b0, 8'h00);
        check("R6", "clk_en restored", 32'(clk_en[7:0]), 32'hFF);
        acc_valid = 1; acc_id = 4'd2; #0.5;
        check("R9", "grant after restore", 32'(acc_grant), 32'h0004);
        acc_valid = 0;

        // R1 reset mid-run clears registers
        rst_n = 0;
        tick();
        rst_n = 1;
        @(negedge clk);
        check("R1", "clk_en after reset", 32'(clk_en), 32'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule